// File: doc/BRIEF.md
# Narrow-Access Write Shadowing Bridge

This block sits between a host bus that issues byte, halfword and word accesses and a register file that accepts only aligned 32-bit reads and writes. A narrow read becomes one aligned word read, and the block returns the addressed lane shifted down to bit 0. A narrow write becomes a read-modify-write of the aligned word. The exception is the three halfwords that describe a data transfer: block size, block count and transfer mode. Writes to these are collected in two shadow words inside the bridge. They are released only when the command halfword is written. At that point the block word and the command word go downstream as two full-word writes, so two halfwords that share one word can never overwrite each other.

Some register files lose a write that follows the previous one too closely when the card clock is slow. To prevent this, every downstream write starts a hold-off interval, counted in microsecond ticks supplied from outside. The host side stalls until the interval ends. The card-clock rate is given as an input in kHz.

Top module: `subword_shadow_bridge`

## Requirements
- R1: A read with `h_size` 0 (byte) or 1 (halfword) is accepted, and in the next cycle a single `d_rd` is issued to the address with its low two bits cleared. In the cycle after that, `h_rvalid` is high and `h_rdata` holds the word shifted right by 8 × `h_addr[1:0]`, masked to 8 or 16 bits.
- R2: A halfword write to offset 0x04 (block size) or 0x06 (block count) is merged into the block shadow word, in bits 15:0 for 0x04 and bits 31:16 for 0x06. It causes no downstream read or write.
- R3: A halfword write to offset 0x0C (transfer mode) is merged into bits 15:0 of the command shadow word. It causes no downstream read or write.
- R4: A halfword write to offset 0x0E (command) first merges into bits 31:16 of the command shadow. If the block shadow is non-zero, it is written to address 0x04 and then cleared, and after that the command shadow is written to 0x0C.
- R5: A command write when the block shadow is zero produces exactly one downstream write, of the command shadow to 0x0C.
- R6: The command shadow is never cleared by a command write. A later command write carries the last transfer-mode halfword.
- R7: Every other halfword write, and every byte write (including bytes at shadowed offsets), does one aligned read and then one write of the same word with only the addressed lane replaced.
- R8: Accesses with `h_size` 2 or 3 (word) pass through as one aligned downstream read or write, with the data unchanged.
- R9: After any downstream write with `card_khz` in 1..400, the bridge waits ceil(4000 / `card_khz`) `us_tick` pulses before it accepts or issues anything else.
- R10: After a downstream write with `card_khz` equal to 0, the hold-off is 10 ticks.
- R11: After a downstream write with `card_khz` above 400, there is no hold-off.
- R12: The hold-off also separates the block write from the command write in the R4 sequence.
- R13: After reset, `h_ready` is high, no downstream strobe is active and both shadow words are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| h_valid | input | 1 | Host request valid |
| h_ready | output | 1 | Host request accepted when high together with `h_valid` |
| h_write | input | 1 | 1 = write, 0 = read |
| h_size | input | 2 | 0 byte, 1 halfword, 2 or 3 word |
| h_addr | input | ADDR_W | Host byte address |
| h_wdata | input | 32 | Write data, right-aligned for narrow writes |
| h_rvalid | output | 1 | Read data valid pulse |
| h_rdata | output | 32 | Read data, right-aligned |
| d_rd | output | 1 | Downstream word read strobe |
| d_wr | output | 1 | Downstream word write strobe |
| d_addr | output | ADDR_W | Downstream word-aligned address |
| d_wdata | output | 32 | Downstream write data |
| d_rdata | input | 32 | Downstream read data, valid the cycle after `d_rd` |
| card_khz | input | KHZ_W | Configured card clock in kHz |
| us_tick | input | 1 | One-cycle pulse per microsecond |

## Verification
Counted from the clock edge that accepts a request:
- A narrow read raises `d_rd` in the first cycle after that edge and `h_rvalid` in the second. The bench samples each strobe on the falling edge of exactly those cycles.
- A read-modify-write logs its write two edges after acceptance.
- A block-plus-command pair logs its two writes one cycle apart, or 1 + H cycles apart when a hold-off of H ticks applies. The bench checks this gap through cycle stamps taken at the logging edge.
- Hold-off length is measured as the number of falling edges with `h_ready` low that follow the write cycle. With a tick every cycle, this must equal the computed tick count.

// File: rtl/ssb_pkg.sv
package ssb_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_WIDE = 2'd3
    } acc_size_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_READ,
        ST_RDATA,
        ST_RMW_RD,
        ST_RMW_WR,
        ST_WRITE,
        ST_BLK,
        ST_CMD
    } seq_state_e;

    typedef struct packed {
        logic        write;
        acc_size_e   size;
        logic [1:0]  lane;
        logic [31:0] data;
    } host_req_t;

    function automatic logic [4:0] lane_shift(input logic [1:0] lane);
        return {lane, 3'b000};
    endfunction

    function automatic logic is_narrow(input acc_size_e sz);
        return (sz == SZ_BYTE) || (sz == SZ_HALF);
    endfunction

    function automatic logic [31:0] lane_mask(input acc_size_e sz, input logic [1:0] lane);
        case (sz)
            SZ_BYTE: return 32'h0000_00FF << lane_shift(lane);
            SZ_HALF: return 32'h0000_FFFF << lane_shift(lane);
            default: return 32'hFFFF_FFFF;
        endcase
    endfunction

    function automatic logic [31:0] lane_pick(input logic [31:0] word, input acc_size_e sz,
                                              input logic [1:0] lane);
        logic [31:0] s;
        s = word >> lane_shift(lane);
        case (sz)
            SZ_BYTE: return {24'h0, s[7:0]};
            SZ_HALF: return {16'h0, s[15:0]};
            default: return word;
        endcase
    endfunction

    function automatic logic [31:0] lane_merge(input logic [31:0] old, input logic [31:0] val,
                                               input acc_size_e sz, input logic [1:0] lane);
        logic [31:0] m;
        m = lane_mask(sz, lane);
        if (!is_narrow(sz)) return val;
        return (old & ~m) | ((val << lane_shift(lane)) & m);
    endfunction

    function automatic int unsigned holdoff_us(input int unsigned khz, input int unsigned slow_khz,
                                               input int unsigned periods, input int unsigned zero_us);
        if (khz == 0) return zero_us;
        if (khz > slow_khz) return 0;
        return (periods * 1000 + khz - 1) / khz;
    endfunction

endpackage

// File: rtl/ssb_holdoff.sv
module ssb_holdoff
    import ssb_pkg::*;
#(
    parameter int unsigned KHZ_W        = 16,
    parameter int unsigned CNT_W        = 16,
    parameter int unsigned SLOW_KHZ     = 400,
    parameter int unsigned CARD_PERIODS = 4,
    parameter int unsigned ZERO_CLK_US  = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic             us_tick,
    input  logic [KHZ_W-1:0] card_khz,
    output logic             busy
);

    localparam logic [KHZ_W-1:0] SLOW_LIM = KHZ_W'(SLOW_KHZ);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] load_val;

    always_comb begin
        load_val = CNT_W'(holdoff_us(32'(card_khz), SLOW_KHZ, CARD_PERIODS, ZERO_CLK_US));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (us_tick && (cnt != '0)) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign busy = (cnt != '0);

    // R9
    slow_load_busy_chk: assert property (@(posedge clk) disable iff (rst)
        (load && (card_khz <= SLOW_LIM)) |=> busy);

    // R11
    fast_load_free_chk: assert property (@(posedge clk) disable iff (rst)
        (load && (card_khz > SLOW_LIM)) |=> !busy);

    // R9
    countdown_step_chk: assert property (@(posedge clk) disable iff (rst)
        (!load && busy) |=> ((cnt == $past(cnt)) || (cnt == $past(cnt) - 1'b1)));

endmodule

// File: rtl/ssb_shadow.sv
module ssb_shadow
    import ssb_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        blk_we,
    input  logic        cmd_we,
    input  logic        blk_clr,
    input  logic        hi_half,
    input  logic [15:0] hdata,
    output logic [31:0] blk_word,
    output logic [31:0] cmd_word
);

    logic [1:0]  lane;
    logic [31:0] hval;

    assign lane = {hi_half, 1'b0};
    assign hval = {16'h0, hdata};

    always_ff @(posedge clk) begin
        if (rst) begin
            blk_word <= '0;
            cmd_word <= '0;
        end else begin
            if (blk_clr) begin
                blk_word <= '0;
            end else if (blk_we) begin
                blk_word <= lane_merge(blk_word, hval, SZ_HALF, lane);
            end
            if (cmd_we) begin
                cmd_word <= lane_merge(cmd_word, hval, SZ_HALF, lane);
            end
        end
    end

    // R4
    blk_clear_chk: assert property (@(posedge clk) disable iff (rst)
        blk_clr |=> (blk_word == 32'h0));

    // R6
    cmd_keep_chk: assert property (@(posedge clk) disable iff (rst)
        !cmd_we |=> $stable(cmd_word));

endmodule

// File: rtl/ssb_seq.sv
module ssb_seq
    import ssb_pkg::*;
#(
    parameter int unsigned           ADDR_W     = 8,
    parameter logic [ADDR_W-1:0]     BLKSZ_OFF  = 'h04,
    parameter logic [ADDR_W-1:0]     BLKCNT_OFF = 'h06,
    parameter logic [ADDR_W-1:0]     XFER_OFF   = 'h0C,
    parameter logic [ADDR_W-1:0]     CMD_OFF    = 'h0E
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              h_valid,
    output logic              h_ready,
    input  logic              h_write,
    input  acc_size_e         h_size,
    input  logic [ADDR_W-1:0] h_addr,
    input  logic [31:0]       h_wdata,
    output logic              h_rvalid,
    output logic [31:0]       h_rdata,
    output logic              d_rd,
    output logic              d_wr,
    output logic [ADDR_W-1:0] d_addr,
    output logic [31:0]       d_wdata,
    input  logic [31:0]       d_rdata,
    input  logic              busy,
    input  logic [31:0]       blk_word,
    input  logic [31:0]       cmd_word,
    output logic              blk_we,
    output logic              cmd_we,
    output logic              blk_clr,
    output logic              sh_hi,
    output logic [15:0]       sh_data
);

    localparam logic [ADDR_W-1:0] BLK_WORD_ADDR = {BLKSZ_OFF[ADDR_W-1:2], 2'b00};
    localparam logic [ADDR_W-1:0] CMD_WORD_ADDR = {CMD_OFF[ADDR_W-1:2], 2'b00};

    seq_state_e        state, state_n;
    host_req_t         req;
    logic [ADDR_W-1:0] req_addr;
    logic              accept;
    logic              half_wr;
    logic              blk_hit, xfer_hit, cmd_hit;

    assign h_ready  = (state == ST_IDLE) && !busy;
    assign accept   = h_valid && h_ready;
    assign half_wr  = h_write && (h_size == SZ_HALF);
    assign blk_hit  = half_wr && ((h_addr == BLKSZ_OFF) || (h_addr == BLKCNT_OFF));
    assign xfer_hit = half_wr && (h_addr == XFER_OFF);
    assign cmd_hit  = half_wr && (h_addr == CMD_OFF);
    assign blk_we   = accept && blk_hit;
    assign cmd_we   = accept && (xfer_hit || cmd_hit);
    assign sh_hi    = h_addr[1];
    assign sh_data  = h_wdata[15:0];

    always_comb begin
        state_n  = state;
        h_rvalid = 1'b0;
        h_rdata  = '0;
        d_rd     = 1'b0;
        d_wr     = 1'b0;
        d_addr   = {req_addr[ADDR_W-1:2], 2'b00};
        d_wdata  = '0;
        blk_clr  = 1'b0;
        case (state)
            ST_IDLE: begin
                if (accept) begin
                    if (!h_write)                  state_n = ST_READ;
                    else if (!is_narrow(h_size))   state_n = ST_WRITE;
                    else if (blk_hit || xfer_hit)  state_n = ST_IDLE;
                    else if (cmd_hit)              state_n = (blk_word != '0) ? ST_BLK : ST_CMD;
                    else                           state_n = ST_RMW_RD;
                end
            end
            ST_READ: begin
                d_rd    = 1'b1;
                state_n = ST_RDATA;
            end
            ST_RDATA: begin
                h_rvalid = 1'b1;
                h_rdata  = lane_pick(d_rdata, req.size, req.lane);
                state_n  = ST_IDLE;
            end
            ST_RMW_RD: begin
                d_rd    = 1'b1;
                state_n = ST_RMW_WR;
            end
            ST_RMW_WR: begin
                d_wr    = 1'b1;
                d_wdata = lane_merge(d_rdata, req.data, req.size, req.lane);
                state_n = ST_IDLE;
            end
            ST_WRITE: begin
                d_wr    = 1'b1;
                d_wdata = req.data;
                state_n = ST_IDLE;
            end
            ST_BLK: begin
                d_wr    = 1'b1;
                d_addr  = BLK_WORD_ADDR;
                d_wdata = blk_word;
                blk_clr = 1'b1;
                state_n = ST_CMD;
            end
            ST_CMD: begin
                if (!busy) begin
                    d_wr    = 1'b1;
                    d_addr  = CMD_WORD_ADDR;
                    d_wdata = cmd_word;
                    state_n = ST_IDLE;
                end
            end
            default: state_n = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            req      <= '0;
            req_addr <= '0;
        end else begin
            state <= state_n;
            if (accept) begin
                req      <= '{write: h_write, size: h_size, lane: h_addr[1:0], data: h_wdata};
                req_addr <= h_addr;
            end
        end
    end

    // R7
    rd_wr_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(d_rd && d_wr));

    // R1
    rvalid_after_rd_chk: assert property (@(posedge clk) disable iff (rst)
        h_rvalid |-> $past(d_rd));

    // R12
    cmd_wait_chk: assert property (@(posedge clk) disable iff (rst)
        (d_wr && (d_addr == CMD_WORD_ADDR) && $past(blk_clr)) |-> !busy);

endmodule

// File: rtl/subword_shadow_bridge.sv
module subword_shadow_bridge
    import ssb_pkg::*;
#(
    parameter int unsigned       ADDR_W       = 8,
    parameter int unsigned       KHZ_W        = 16,
    parameter int unsigned       CNT_W        = 16,
    parameter int unsigned       SLOW_KHZ     = 400,
    parameter int unsigned       CARD_PERIODS = 4,
    parameter int unsigned       ZERO_CLK_US  = 10,
    parameter logic [ADDR_W-1:0] BLKSZ_OFF    = 'h04,
    parameter logic [ADDR_W-1:0] BLKCNT_OFF   = 'h06,
    parameter logic [ADDR_W-1:0] XFER_OFF     = 'h0C,
    parameter logic [ADDR_W-1:0] CMD_OFF      = 'h0E
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              h_valid,
    output logic              h_ready,
    input  logic              h_write,
    input  logic [1:0]        h_size,
    input  logic [ADDR_W-1:0] h_addr,
    input  logic [31:0]       h_wdata,
    output logic              h_rvalid,
    output logic [31:0]       h_rdata,
    output logic              d_rd,
    output logic              d_wr,
    output logic [ADDR_W-1:0] d_addr,
    output logic [31:0]       d_wdata,
    input  logic [31:0]       d_rdata,
    input  logic [KHZ_W-1:0]  card_khz,
    input  logic              us_tick
);

    localparam logic [KHZ_W-1:0] SLOW_LIM = KHZ_W'(SLOW_KHZ);

    logic        busy;
    logic [31:0] blk_word, cmd_word;
    logic        blk_we, cmd_we, blk_clr, sh_hi;
    logic [15:0] sh_data;
    acc_size_e   size_in;

    assign size_in = acc_size_e'(h_size);

    ssb_seq #(
        .ADDR_W(ADDR_W), .BLKSZ_OFF(BLKSZ_OFF), .BLKCNT_OFF(BLKCNT_OFF),
        .XFER_OFF(XFER_OFF), .CMD_OFF(CMD_OFF)
    ) u_seq (
        .clk(clk), .rst(rst),
        .h_valid(h_valid), .h_ready(h_ready), .h_write(h_write), .h_size(size_in),
        .h_addr(h_addr), .h_wdata(h_wdata), .h_rvalid(h_rvalid), .h_rdata(h_rdata),
        .d_rd(d_rd), .d_wr(d_wr), .d_addr(d_addr), .d_wdata(d_wdata), .d_rdata(d_rdata),
        .busy(busy), .blk_word(blk_word), .cmd_word(cmd_word),
        .blk_we(blk_we), .cmd_we(cmd_we), .blk_clr(blk_clr),
        .sh_hi(sh_hi), .sh_data(sh_data)
    );

    ssb_shadow u_shadow (
        .clk(clk), .rst(rst),
        .blk_we(blk_we), .cmd_we(cmd_we), .blk_clr(blk_clr),
        .hi_half(sh_hi), .hdata(sh_data),
        .blk_word(blk_word), .cmd_word(cmd_word)
    );

    ssb_holdoff #(
        .KHZ_W(KHZ_W), .CNT_W(CNT_W), .SLOW_KHZ(SLOW_KHZ),
        .CARD_PERIODS(CARD_PERIODS), .ZERO_CLK_US(ZERO_CLK_US)
    ) u_hold (
        .clk(clk), .rst(rst), .load(d_wr), .us_tick(us_tick),
        .card_khz(card_khz), .busy(busy)
    );

    // R2 R3
    shadow_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (h_valid && h_ready && h_write && (h_size == 2'd1) &&
         ((h_addr == BLKSZ_OFF) || (h_addr == BLKCNT_OFF) || (h_addr == XFER_OFF)))
        |=> (!d_wr && !d_rd));

    // R9
    slow_spacing_chk: assert property (@(posedge clk) disable iff (rst)
        (d_wr && (card_khz <= SLOW_LIM)) |=> !d_wr);

endmodule

// File: tb/subword_shadow_bridge_test.sv
module subword_shadow_bridge_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        h_valid = 1'b0;
    logic        h_ready;
    logic        h_write = 1'b0;
    logic [1:0]  h_size = 2'd0;
    logic [7:0]  h_addr = 8'h0;
    logic [31:0] h_wdata = 32'h0;
    logic        h_rvalid;
    logic [31:0] h_rdata;
    logic        d_rd, d_wr;
    logic [7:0]  d_addr;
    logic [31:0] d_wdata;
    logic [31:0] d_rdata = 32'h0;
    logic [15:0] card_khz = 16'd1000;
    logic        us_tick = 1'b1;

    int tests = 0;
    int fails = 0;
    int cyc   = 0;

    logic [31:0] mem [64];
    logic [7:0]  wl_addr [256];
    logic [31:0] wl_data [256];
    int          wl_cyc  [256];
    logic [7:0]  wn = 8'd0;
    int          rn = 0;

    always #5 clk = ~clk;

    subword_shadow_bridge uut (
        .clk(clk), .rst(rst), .h_valid(h_valid), .h_ready(h_ready), .h_write(h_write),
        .h_size(h_size), .h_addr(h_addr), .h_wdata(h_wdata), .h_rvalid(h_rvalid),
        .h_rdata(h_rdata), .d_rd(d_rd), .d_wr(d_wr), .d_addr(d_addr), .d_wdata(d_wdata),
        .d_rdata(d_rdata), .card_khz(card_khz), .us_tick(us_tick)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (rst) begin
            for (int i = 0; i < 64; i++) mem[i] <= 32'h1357_9BDF ^ (32'(i) * 32'h0103_0507);
            wn <= 8'd0;
            rn <= 0;
        end else begin
            if (d_rd) begin
                d_rdata <= mem[d_addr[7:2]];
                rn <= rn + 1;
            end
            if (d_wr) begin
                mem[d_addr[7:2]] <= d_wdata;
                wl_addr[wn] <= d_addr;
                wl_data[wn] <= d_wdata;
                wl_cyc[wn]  <= cyc;
                wn <= wn + 8'd1;
            end
        end
    end

    always @(posedge clk) begin
        if (cyc == 150000) begin
            tests++;
            fails++;
            $display("FAIL timeout: run hung, act=%0d exp<150000 cycles", cyc);
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic host_op(input logic wr, input logic [1:0] sz, input logic [7:0] a,
                           input logic [31:0] wd);
        @(negedge clk);
        h_valid = 1'b1; h_write = wr; h_size = sz; h_addr = a; h_wdata = wd;
        while (!h_ready) @(negedge clk);
        @(negedge clk);
        h_valid = 1'b0;
    endtask

    task automatic settle();
        repeat (3) @(negedge clk);
        while (!h_ready) @(negedge clk);
    endtask

    function automatic logic [31:0] exp_pick(input logic [31:0] w, input logic [1:0] sz,
                                             input logic [1:0] off);
        logic [31:0] s;
        s = w >> (8 * off);
        if (sz == 2'd0) return s & 32'hFF;
        if (sz == 2'd1) return s & 32'hFFFF;
        return w;
    endfunction

    function automatic logic [31:0] exp_merge(input logic [31:0] w, input logic [31:0] v,
                                              input logic [1:0] sz, input logic [1:0] off);
        logic [31:0] m;
        m = (sz == 2'd0) ? 32'hFF : 32'hFFFF;
        m = m << (8 * off);
        return (w & ~m) | ((v << (8 * off)) & m);
    endfunction

    function automatic int exp_hold(input int khz);
        if (khz == 0) return 10;
        if (khz <= 400) return (4000 + khz - 1) / khz;
        return 0;
    endfunction

    task automatic do_read(input logic [1:0] sz, input logic [7:0] a, input string req);
        logic [31:0] w;
        int rb;
        w  = mem[a[7:2]];
        rb = rn;
        host_op(1'b0, sz, a, 32'h0);
        chk({req, " d_rd"}, {31'h0, d_rd}, 32'h1);
        chk({req, " d_addr"}, {24'h0, d_addr}, {24'h0, a & 8'hFC});
        chk({req, " early rvalid"}, {31'h0, h_rvalid}, 32'h0);
        @(negedge clk);
        chk({req, " rvalid"}, {31'h0, h_rvalid}, 32'h1);
        chk({req, " rdata"}, h_rdata, exp_pick(w, sz, a[1:0]));
        settle();
        chk({req, " one read"}, 32'(rn - rb), 32'h1);
    endtask

    task automatic do_rmw(input logic [1:0] sz, input logic [7:0] a, input logic [31:0] v);
        logic [31:0] w;
        logic [7:0]  nb;
        int          rb;
        w  = mem[a[7:2]];
        nb = wn;
        rb = rn;
        host_op(1'b1, sz, a, v);
        settle();
        chk("R7 rmw writes", 32'(wn - nb), 32'h1);
        chk("R7 rmw reads", 32'(rn - rb), 32'h1);
        chk("R7 rmw addr", {24'h0, wl_addr[nb]}, {24'h0, a & 8'hFC});
        chk("R7 rmw data", wl_data[nb], exp_merge(w, v, sz, a[1:0]));
    endtask

    task automatic shadow_wr(input logic [7:0] a, input logic [15:0] v, input string req);
        logic [7:0] nb;
        int rb;
        nb = wn;
        rb = rn;
        host_op(1'b1, 2'd1, a, {16'hBEEF, v});
        settle();
        chk({req, " no write"}, 32'(wn - nb), 32'h0);
        chk({req, " no read"}, 32'(rn - rb), 32'h0);
    endtask

    task automatic measure_hold(input int khz);
        int n;
        card_khz = 16'(khz);
        settle();
        host_op(1'b1, 2'd2, 8'h30, 32'(khz));
        chk("R9 word write strobe", {31'h0, d_wr}, 32'h1);
        n = 0;
        @(negedge clk);
        while (!h_ready) begin
            n++;
            @(negedge clk);
        end
        if (khz == 0)        chk("R10 zero-clock hold", 32'(n), 32'(exp_hold(khz)));
        else if (khz <= 400) chk("R9 slow hold", 32'(n), 32'(exp_hold(khz)));
        else                 chk("R11 fast no hold", 32'(n), 32'(exp_hold(khz)));
    endtask

    initial begin
        logic [7:0] nb;
        int rb;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R13 reset state
        chk("R13 ready", {31'h0, h_ready}, 32'h1);
        chk("R13 d_rd", {31'h0, d_rd}, 32'h0);
        chk("R13 d_wr", {31'h0, d_wr}, 32'h0);
        chk("R13 rvalid", {31'h0, h_rvalid}, 32'h0);

        // R1 narrow reads over every lane of two words
        for (int base = 8'h10; base <= 8'h14; base += 4) begin
            for (int off = 0; off < 4; off++) do_read(2'd0, 8'(base + off), "R1 byte");
            do_read(2'd1, 8'(base), "R1 half lo");
            do_read(2'd1, 8'(base + 2), "R1 half hi");
        end
        // R8 word read pass-through
        do_read(2'd2, 8'h18, "R8 word");
        do_read(2'd3, 8'h1C, "R8 wide");

        // R7 byte and halfword read-modify-write
        for (int off = 0; off < 4; off++) do_rmw(2'd0, 8'(8'h20 + off), 32'hA0 + 32'(off));
        do_rmw(2'd1, 8'h24, 32'h0000_5A5A);
        do_rmw(2'd1, 8'h26, 32'h0000_C3C3);
        do_rmw(2'd0, 8'h0E, 32'h0000_0077);
        do_rmw(2'd0, 8'h05, 32'h0000_0099);

        // R8 word write pass-through
        nb = wn; rb = rn;
        host_op(1'b1, 2'd2, 8'h28, 32'hDEAD_BEEF);
        settle();
        chk("R8 word write count", 32'(wn - nb), 32'h1);
        chk("R8 word write no read", 32'(rn - rb), 32'h0);
        chk("R8 word write data", wl_data[nb], 32'hDEAD_BEEF);

        // R13 R3 R5: shadows start at zero, transfer mode deferred
        shadow_wr(8'h0C, 16'h0011, "R3 xfer");
        nb = wn;
        host_op(1'b1, 2'd1, 8'h0E, 32'h0000_2233);
        settle();
        chk("R5 single cmd write", 32'(wn - nb), 32'h1);
        chk("R5 cmd addr", {24'h0, wl_addr[nb]}, 32'h0C);
        chk("R5 cmd data", wl_data[nb], 32'h2233_0011);

        // R2 R4: block halfwords deferred then flushed ahead of command
        shadow_wr(8'h04, 16'h0200, "R2 blksize");
        shadow_wr(8'h06, 16'h0005, "R2 blkcount");
        nb = wn;
        host_op(1'b1, 2'd1, 8'h0E, 32'h0000_4455);
        settle();
        chk("R4 two writes", 32'(wn - nb), 32'h2);
        chk("R4 blk addr", {24'h0, wl_addr[nb]}, 32'h04);
        chk("R4 blk data", wl_data[nb], 32'h0005_0200);
        chk("R4 cmd addr", {24'h0, wl_addr[8'(nb + 1)]}, 32'h0C);
        chk("R6 cmd keeps xfer", wl_data[8'(nb + 1)], 32'h4455_0011);
        chk("R11 back-to-back gap", 32'(wl_cyc[8'(nb + 1)] - wl_cyc[nb]), 32'h1);

        // R4 block shadow cleared, R6 transfer mode retained
        nb = wn;
        host_op(1'b1, 2'd1, 8'h0E, 32'h0000_6677);
        settle();
        chk("R4 blk cleared single write", 32'(wn - nb), 32'h1);
        chk("R6 cmd data", wl_data[nb], 32'h6677_0011);

        // R12 hold-off between block and command writes
        card_khz = 16'd100;
        settle();
        shadow_wr(8'h06, 16'h0001, "R2 blkcount slow");
        nb = wn;
        host_op(1'b1, 2'd1, 8'h0E, 32'h0000_0102);
        while (wn != 8'(nb + 2)) @(negedge clk);
        settle();
        chk("R12 blk data", wl_data[nb], 32'h0001_0000);
        chk("R12 cmd data", wl_data[8'(nb + 1)], 32'h0102_0011);
        chk("R12 gap", 32'(wl_cyc[8'(nb + 1)] - wl_cyc[nb]), 32'(1 + exp_hold(100)));

        // R9 R10 R11 hold-off sweep
        measure_hold(0);
        measure_hold(1);
        measure_hold(3);
        measure_hold(7);
        measure_hold(100);
        measure_hold(333);
        measure_hold(400);
        measure_hold(401);
        measure_hold(1000);
        measure_hold(65535);

        // R9 slow RMW also holds off the next read
        card_khz = 16'd400;
        settle();
        do_rmw(2'd0, 8'h2D, 32'h0000_0042);
        do_read(2'd0, 8'h2D, "R9 read after slow rmw");

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule